// File: doc/BRIEF.md
# Mode-Banked Register File

This block is a 32-bit register file for a processor core that runs in one of four privilege modes. Software always sees sixteen registers, numbered 0 to 15, but the file holds twenty-seven physical words. The current mode decides which physical word each register number selects. The low registers are common to every mode. The upper registers are duplicated for some modes, so an exception handler can use them without saving the interrupted code's copies first.

The file has two combinational read ports and one write port. Each port takes a 4-bit register number. A single 2-bit mode input applies to all three ports in a given cycle. Register 15 holds the program counter together with the status bits. It is one physical word, and every mode sees the same word. Decode, arithmetic and the logic that switches modes are outside this block.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset, active high, clears every one of the twenty-seven physical words to zero.
- R2: Register numbers 0 to 7 select the same physical word in all four modes.
- R3: In fast-interrupt mode, register numbers 8 to 14 select seven words that only that mode can reach. A write to one of them leaves what the other modes read at that number unchanged, and a write from another mode leaves these words unchanged.
- R4: User, normal-interrupt and supervisor modes share one physical word for each of the register numbers 8 to 12.
- R5: Supervisor mode and normal-interrupt mode each own a private pair for register numbers 13 and 14. User mode uses the base pair. A write through any one of these three pairs is not seen through the other two.
- R6: Register number 15 selects one physical word that all four modes share.
- R7: The mode input is encoded as 2'b00 user, 2'b01 fast interrupt, 2'b10 normal interrupt and 2'b11 supervisor.
- R8: A read of the word being written in the same cycle returns the old contents. The new value can be read from the cycle after the clock edge.
- R9: The two read ports are independent. Each returns the word that its own register number selects under the current mode, and both return the same data when their numbers match.
- R10: While the write enable is low, no word changes, whatever the write number and write data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Current mode, encoded as given in R7 |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Data read on port A |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Data read on port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Data to write |

## Verification
The assertions check several rules on every cycle. Data written to registers 0 to 7 or 15 must reappear in any mode on the next cycle. A write and a read at the same number in an unchanged mode must return the written data one cycle later. Port A must hold steady when nothing was written. The two ports must agree when their numbers match. The zero state must hold on the first cycle after reset. Bank isolation is different: it only shows up over sequences of several cycles, where a value is written in one mode and then read back at the same number in the other modes. Only the bench's scenarios reach that behaviour. The scenarios include a full sweep that fills all sixteen numbers in all four modes, targeted cross-mode writes on the banked numbers, read-during-write cycles, cycles with the write enable low, and a long mixed stream of random reads and writes.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data
);
  localparam int NPHYS    = 27;
  localparam int PW       = $clog2(NPHYS);
  localparam int FIQ_BASE = 16;
  localparam int IRQ_BASE = FIQ_BASE + 7;
  localparam int SVC_BASE = IRQ_BASE + 2;

  localparam logic [1:0] M_FIQ = 2'b01;
  localparam logic [1:0] M_IRQ = 2'b10;
  localparam logic [1:0] M_SVC = 2'b11;

  function automatic logic [PW-1:0] phys_of(input logic [1:0] m, input logic [3:0] r);
    logic [PW-1:0] p;
    p = PW'(r);
    if (m == M_FIQ && r >= 4'd8 && r <= 4'd14)
      p = PW'(FIQ_BASE + int'(r) - 8);
    else if (m == M_IRQ && r >= 4'd13 && r <= 4'd14)
      p = PW'(IRQ_BASE + int'(r) - 13);
    else if (m == M_SVC && r >= 4'd13 && r <= 4'd14)
      p = PW'(SVC_BASE + int'(r) - 13);
    return p;
  endfunction

  logic [DW-1:0] bank [NPHYS];
  logic [PW-1:0] sel_a, sel_b, sel_w;

  assign sel_a = phys_of(mode, rd_a_idx);
  assign sel_b = phys_of(mode, rd_b_idx);
  assign sel_w = phys_of(mode, wr_idx);

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPHYS; p++) begin
      if (rst)
        bank[p] <= '0;
      else if (wr_en && sel_w == PW'(p))
        bank[p] <= wr_data;
    end
  end

  assign rd_a_data = bank[sel_a];
  assign rd_b_data = bank[sel_b];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

  p_low_shared_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_idx) < 4'd8 && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

  p_pc_shared_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_idx) == 4'd15 && rd_b_idx == 4'd15)
      |-> rd_b_data == $past(wr_data));

  p_write_visible_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && mode == $past(mode) && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

  p_ports_agree_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && mode == $past(mode) && rd_a_idx == $past(rd_a_idx))
      |-> $stable(rd_a_data));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] mdl [27];

  always #2 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst(rst), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // Word slots per R2..R7: 0-15 base, 16-22 fast-interrupt 8-14, 23-24 irq 13-14, 25-26 svc 13-14
  function automatic int slot(input logic [1:0] m, input logic [3:0] r);
    case (m)
      2'b01:   return (r >= 8 && r <= 14) ? 16 + int'(r) - 8 : int'(r);
      2'b10:   return (r == 13 || r == 14) ? 23 + int'(r) - 13 : int'(r);
      2'b11:   return (r == 13 || r == 14) ? 25 + int'(r) - 13 : int'(r);
      default: return int'(r);
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] m, input logic [3:0] r);
    if (r < 8)                return "R2";
    if (r == 15)              return "R6";
    if (m == 2'b01)           return "R3";
    if (r <= 12)              return "R4";
    return "R5";
  endfunction

  task automatic cyc(input logic [1:0] m, input logic [3:0] ia, input logic [3:0] ib,
                     input logic we, input logic [3:0] iw, input logic [31:0] dw,
                     input string tag);
    item_t it;
    @(negedge clk);
    mode = m; rd_a_idx = ia; rd_b_idx = ib;
    wr_en = we; wr_idx = iw; wr_data = dw;
    it.exp_a = mdl[slot(m, ia)];
    it.exp_b = mdl[slot(m, ib)];
    it.tag   = tag;
    sb.push_back(it);
    if (we) mdl[slot(m, iw)] = dw;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        tests++;
        if (rd_a_data !== it.exp_a || rd_b_data !== it.exp_b) begin
          fails++;
          $display("FAIL %s: port A got %h expected %h, port B got %h expected %h",
                   it.tag, rd_a_data, it.exp_a, rd_b_data, it.exp_b);
        end
      end
    end
  end

  initial begin : watchdog
    #(150000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, got hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] lfsr;
    for (int p = 0; p < 27; p++) mdl[p] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every number in every mode reads zero after reset
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 16; i++)
        cyc(2'(m), 4'(i), 4'(15 - i), 1'b0, 4'd0, 32'd0, "R1");

    // R8: fill every number in every mode while reading it in the same cycle
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 16; i++)
        cyc(2'(m), 4'(i), 4'(i), 1'b1, 4'(i), 32'hA500_0000 ^ (m << 12) ^ (i << 4) ^ 32'h3, "R8");

    // R2..R6: sweep reads across all modes after the fill
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 16; i++)
        cyc(2'(m), 4'(i), 4'((i + 7) % 16), 1'b0, 4'd0, 32'd0, req_of(2'(m), 4'(i)));

    // R3: fast-interrupt write to 9 is private
    cyc(2'b01, 4'd9, 4'd9, 1'b1, 4'd9, 32'hDEAD_BEEF, "R3");
    cyc(2'b00, 4'd9, 4'd9, 1'b0, 4'd0, 32'd0, "R3");
    cyc(2'b11, 4'd9, 4'd14, 1'b0, 4'd0, 32'd0, "R3");
    cyc(2'b01, 4'd9, 4'd8, 1'b0, 4'd0, 32'd0, "R3");
    // R4: user write to 11 seen in irq and svc, not in fast-interrupt
    cyc(2'b00, 4'd11, 4'd11, 1'b1, 4'd11, 32'h1111_0B0B, "R4");
    cyc(2'b10, 4'd11, 4'd12, 1'b0, 4'd0, 32'd0, "R4");
    cyc(2'b11, 4'd11, 4'd10, 1'b0, 4'd0, 32'd0, "R4");
    cyc(2'b01, 4'd11, 4'd11, 1'b0, 4'd0, 32'd0, "R4");
    // R5: irq write to 14 is not seen by svc or user
    cyc(2'b10, 4'd14, 4'd13, 1'b1, 4'd14, 32'hFFFF_FFFF, "R5");
    cyc(2'b11, 4'd14, 4'd13, 1'b0, 4'd0, 32'd0, "R5");
    cyc(2'b00, 4'd14, 4'd13, 1'b0, 4'd0, 32'd0, "R5");
    cyc(2'b10, 4'd14, 4'd13, 1'b0, 4'd0, 32'd0, "R5");
    // R6: program counter word written in svc, seen by fast-interrupt
    cyc(2'b11, 4'd15, 4'd0, 1'b1, 4'd15, 32'h8000_0004, "R6");
    cyc(2'b01, 4'd15, 4'd15, 1'b0, 4'd0, 32'd0, "R6");
    // R7: code 2'b11 is supervisor, 2'b10 normal interrupt
    cyc(2'b11, 4'd13, 4'd13, 1'b1, 4'd13, 32'h5555_AAAA, "R7");
    cyc(2'b10, 4'd13, 4'd14, 1'b0, 4'd0, 32'd0, "R7");
    cyc(2'b11, 4'd13, 4'd14, 1'b0, 4'd0, 32'd0, "R7");
    // R10: enable low with live write number and data
    cyc(2'b00, 4'd3, 4'd15, 1'b0, 4'd3, 32'h0BAD_0BAD, "R10");
    cyc(2'b01, 4'd3, 4'd10, 1'b0, 4'd10, 32'h0BAD_0BAD, "R10");
    cyc(2'b01, 4'd3, 4'd10, 1'b0, 4'd0, 32'd0, "R10");

    // R9: mixed random stream, independent port numbers
    lfsr = 32'hC0FF_EE01;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[1:0], lfsr[5:2], lfsr[9:6], lfsr[10] & lfsr[11], lfsr[15:12],
          lfsr ^ 32'h1357_9BDF, "R9");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule